// File: doc/BRIEF.md
# Exclusive-OR Phase Error Meter

This block compares a reference square wave with a feedback square wave. Both come from a loop running at a fixed fraction of the system clock. The mismatch signal is the exclusive-OR of the two inputs. It leaves the block combinationally so that a following loop filter can use it directly.

Alongside it, a saturating counter measures how many clock cycles the mismatch lasts while the reference is high. The counter stops when the mismatch ends and is cleared whenever the reference is low. A one-cycle strobe marks the cycle in which the measured length can be read. The count is for observation only and does not feed the loop.

Neither output is a stream, so the block has no handshake. The strobe is a plain pulse with no ready and no back-pressure. A consumer that misses it can still read the count until the reference goes low.

Top module: `phase_err_meter`

## Requirements
- R1: `err_xor` equals `ref_in` XOR `fb_in` at all times, with no register in the path.
- R2: At each rising clock edge where `ref_in` is 1 and `err_xor` is 1, `err_count` increases by one unless it is already at its maximum.
- R3: At a rising edge where `ref_in` is 1 and `err_xor` is 0, `err_count` keeps its value.
- R4: At every rising edge where `ref_in` is 0, `err_count` becomes 0, whatever the value of `err_xor`.
- R5: `err_count` saturates at 2^CNT_W-1 (32767 by default) and does not wrap.
- R6: `count_valid` is 1 for exactly one cycle, the cycle in which the counting condition (`ref_in` and `err_xor` both 1) has just ended after being true at the previous edge. In that cycle `err_count` holds the length of the run in cycles.
- R7: `rst_n` is an active-low synchronous reset. While it is sampled low, `err_count` is 0 and `count_valid` stays 0.
- R8: Take square waves of period M clocks (M = 16) with a 50 % duty cycle, where the feedback lags or leads the reference by d clocks, 1 ≤ d ≤ M/2. Each reference period then produces one strobe with `err_count` equal to d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, M times the reference rate |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Reference square wave, synchronous to clk |
| fb_in | input | 1 | Feedback square wave, synchronous to clk |
| err_xor | output | 1 | Mismatch signal for the loop filter |
| err_count | output | CNT_W | Measured mismatch length in clock cycles |
| count_valid | output | 1 | One-cycle strobe: `err_count` holds a finished measurement |

## Verification
The bench sweeps feedback that lags and feedback that leads, up to the half-period offset. When the feedback leads, the run ends on the falling edge of the reference, so a design that cleared the count before strobing would report 0 instead of d. A mismatch held for more than 32767 cycles would wrap to a small value in a design without saturation. The bench also holds the reference high after a run to confirm the count is held, and it drives a mismatch while the reference is low. In that case a design that gated only on the XOR would count, and a spurious strobe would appear.

// File: rtl/phm_pkg.sv
package phm_pkg;
  localparam int unsigned PHM_DEF_CNT_W = 15;

  function automatic logic [PHM_DEF_CNT_W-1:0] phm_all_ones();
    return '1;
  endfunction
endpackage

// File: rtl/phm_xor_cmp.sv
module phm_xor_cmp (
  input  logic ref_in,
  input  logic fb_in,
  output logic err_xor,
  output logic run_en
);
  always_comb begin
    err_xor = ref_in ^ fb_in;
    run_en  = ref_in & err_xor;
  end
endmodule

// File: rtl/phm_run_counter.sv
module phm_run_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run_en,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic at_max;
  assign at_max = (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)              count <= '0;
    else if (clr)            count <= '0;
    else if (run_en && !at_max) count <= count + 1'b1;
  end

  AST_CLEAR_ON_REF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R4
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !run_en) |=> $stable(count)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && run_en && count != CNT_MAX) |=> (count == $past(count) + 1'b1)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && count == CNT_MAX) |=> (count == CNT_MAX)); // R5
endmodule

// File: rtl/phm_run_strobe.sv
module phm_run_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic done
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_en;
  end

  assign done = run_q & ~run_en;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
endmodule

// File: rtl/phase_err_meter.sv
module phase_err_meter
  import phm_pkg::*;
#(
  parameter int unsigned CNT_W = PHM_DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             fb_in,
  output logic             err_xor,
  output logic [CNT_W-1:0] err_count,
  output logic             count_valid
);
  logic run_en;

  phm_xor_cmp u_cmp (
    .ref_in (ref_in),
    .fb_in  (fb_in),
    .err_xor(err_xor),
    .run_en (run_en)
  );

  phm_run_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~ref_in),
    .run_en(run_en),
    .count (err_count)
  );

  phm_run_strobe u_stb (
    .clk   (clk),
    .rst_n (rst_n),
    .run_en(run_en),
    .done  (count_valid)
  );

  AST_STROBE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    count_valid |-> (err_count != '0)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (err_count == '0 && !count_valid)); // R7
endmodule

// File: tb/phase_err_meter_bench.sv
module phase_err_meter_bench;
  localparam int M     = 16;
  localparam int CNT_W = 15;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic err_xor;
  logic [CNT_W-1:0] err_count;
  logic count_valid;

  int n_checks = 0;
  int n_fails  = 0;
  int exp_q[$];
  bit prev_valid = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phase_err_meter #(.CNT_W(CNT_W)) u_phase_err_meter (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .err_xor(err_xor), .err_count(err_count), .count_valid(count_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic f);
    @(posedge clk); #1;
    ref_in = r;
    fb_in  = f;
  endtask

  // monitor: scoreboard pop on each strobe, mismatch signal every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(err_xor == (ref_in ^ fb_in), "R1 err_xor", err_xor, ref_in ^ fb_in);
      if (count_valid) begin
        chk(!prev_valid, "R6 strobe width", 2, 1);
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected strobe", int'(err_count), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(err_count) == e, "R8 run length", int'(err_count), e);
        end
      end
      prev_valid = count_valid;
    end else prev_valid = 1'b0;
  end

  task automatic burst(input int lag, input int periods);
    for (int p = 0; p < periods; p++) begin
      for (int c = 0; c < M; c++) begin
        int ph;
        if (c == 0 && lag != 0) exp_q.push_back(lag < 0 ? -lag : lag);
        ph = (((c - lag) % M) + M) % M;
        step(c < M/2, ph < M/2);
      end
    end
    repeat (4) step(1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    // R7: reset with a live mismatch
    step(1'b1, 1'b0);
    repeat (3) step(1'b1, 1'b0);
    @(negedge clk);
    chk(err_count == 0, "R7 reset count", int'(err_count), 0);
    chk(!count_valid, "R7 reset strobe", count_valid, 0);
    step(1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0);

    // R8: lagging and leading feedback sweeps
    for (int d = 1; d <= M/2; d++) burst(d, 3);
    for (int d = 1; d <= M/2; d++) burst(-d, 3);
    burst(0, 2);
    @(negedge clk);
    chk(exp_q.size() == 0, "R6 strobes seen", exp_q.size(), 0);

    // R2: count steps by one per cycle
    repeat (5) step(1'b1, 1'b0);
    @(negedge clk);
    chk(err_count == 4, "R2 increment", int'(err_count), 4);

    // R5: long run saturates
    exp_q.push_back(CMAX);
    repeat (CMAX + 4) step(1'b1, 1'b0);
    @(negedge clk);
    chk(err_count == CMAX, "R5 saturate", int'(err_count), CMAX);
    step(1'b1, 1'b1);
    repeat (3) step(1'b1, 1'b1);
    @(negedge clk);
    chk(err_count == CMAX, "R3 hold", int'(err_count), CMAX);
    chk(exp_q.size() == 0, "R6 saturated strobe", exp_q.size(), 0);

    // R4: mismatch with reference low clears and never counts
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    @(negedge clk);
    chk(err_count == 0, "R4 clear", int'(err_count), 0);
    chk(err_xor == 1'b1, "R1 mismatch while ref low", err_xor, 1);
    repeat (4) step(1'b0, 1'b1);
    @(negedge clk);
    chk(err_count == 0, "R4 no count while ref low", int'(err_count), 0);

    // R7: reset in the middle of a run drops it without a strobe
    step(1'b1, 1'b0);
    repeat (3) step(1'b1, 1'b0);
    @(posedge clk); #1 rst_n = 1'b0;
    step(1'b1, 1'b0);
    @(negedge clk);
    chk(err_count == 0, "R7 mid-run reset", int'(err_count), 0);
    step(1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0);
    @(negedge clk);
    chk(!count_valid && err_count == 0, "R7 quiet after reset", int'(err_count), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule